// File: doc/BRIEF.md
# Byte-Field Logical Combine Sequencer

This block applies a bitwise AND, OR or exclusive OR to operands held in a byte-addressed memory and writes each result byte back over the first operand. A command carries the operation, the mode, two addresses, a length and an immediate byte. In field mode the block combines a run of bytes at the first address with an equal run at the second address. In immediate mode it combines a single byte at the first address with the 8-bit immediate.

The block works through memory one byte at a time over a single-port synchronous RAM interface. For each byte it reads, combines and writes back before it reads the next byte. While it writes, it gathers a zero-result flag across the whole field. When the last byte has been written, it raises a one-cycle done pulse together with a one-bit condition code.

Top module: `bytefield_logic_engine`

## Requirements
- R1: `opSel` picks the operation: 0 = AND, 1 = OR, 2 and 3 = exclusive OR. Each result bit depends only on the matching bit of each operand.
- R2: In field mode (`modeImm`=0), `lenCode`+1 bytes are processed, from 1 byte up to 256 bytes. Result byte i is combined from the bytes at `addrA`+i and `addrB`+i and is written to `addrA`+i. No other byte is written.
- R3: Bytes are processed in ascending address order. Each byte's write completes before the next byte is read, so overlapping fields see results that were written earlier.
- R4: In immediate mode (`modeImm`=1), exactly one byte at `addrA` is combined with `immByte` and replaced, and `lenCode` is ignored. For example, 0xC5 AND 0xFA gives 0xC0, and 0x05 OR 0xF0 gives 0xF5.
- R5: `condCode` is 0 when every bit of the whole result is zero, and 1 otherwise.
- R6: Exclusive OR in field mode with `addrA` equal to `addrB` clears the whole field to zero and gives `condCode` 0.
- R7: `done` is high for exactly one cycle, in the cycle after the last write. `condCode` takes its new value in that same cycle and then holds it until the next completion.
- R8: A `startReq` that arrives while `busy` is high is ignored. It does not alter the operation in progress, its memory traffic or its timing.
- R9: A synchronous active-high `rst` returns the block to idle, with `busy`, `done`, `condCode` and `memEn` low.
- R10: The memory has one-cycle read latency. `memWe` is high only together with `memEn`, and the memory is idle while the block is idle. An operation takes 3 cycles per byte in field mode and 2 cycles in immediate mode, so `done` follows the accepted start by 3·n+1 cycles in field mode and by 3 cycles in immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Command request, accepted only when idle |
| opSel | input | 2 | Operation: 0 AND, 1 OR, 2/3 XOR |
| modeImm | input | 1 | 1 = immediate mode, 0 = field mode |
| addrA | input | ADDR_W | First operand and destination address |
| addrB | input | ADDR_W | Second operand address (field mode) |
| lenCode | input | LEN_W | Byte count minus one (field mode) |
| immByte | input | 8 | Immediate operand (immediate mode) |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| condCode | output | 1 | 0 when the whole result is zero, else 1 |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid one cycle after a read |

## Verification
The assertions take it for granted that reset is held for at least one clock edge before any checked cycle. They also assume that `memRdata` comes from a memory with exactly one cycle of read latency, because the timing of the write strobes is tied to that latency. The bench keeps within these limits: it holds reset for several cycles, and it models the memory as a registered array that answers every read one cycle later. It changes command inputs only at falling edges, both for accepted commands and for the deliberate intrusions during a busy operation.

// File: rtl/bfl_pkg.sv
package bfl_pkg;

  localparam int BYTE_W = 8;

  typedef logic [1:0] opCode_t;
  localparam opCode_t OP_AND = 2'd0;
  localparam opCode_t OP_OR  = 2'd1;
  localparam opCode_t OP_XOR = 2'd2;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;   // capture a new command
    logic rdA;    // read first-operand byte
    logic rdB;    // read second-operand byte
    logic wr;     // write the combined byte
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_WR,
    ST_FIN
  } state_t;

  function automatic logic [BYTE_W-1:0] applyOp(input opCode_t op,
                                                input logic [BYTE_W-1:0] lhs,
                                                input logic [BYTE_W-1:0] rhs);
    logic [BYTE_W-1:0] res;
    case (op)
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      default: res = lhs ^ rhs;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/bfl_ctrl.sv
module bfl_ctrl
  import bfl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startReq,
  input  logic    cmdImm,
  input  logic    lastByte,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.load  = 1'b1;
          stateNext = ST_RDA;
        end
      end
      ST_RDA: begin
        stb.rdA   = 1'b1;
        stateNext = cmdImm ? ST_WR : ST_RDB;
      end
      ST_RDB: begin
        stb.rdB   = 1'b1;
        stateNext = ST_WR;
      end
      ST_WR: begin
        stb.wr    = 1'b1;
        stateNext = lastByte ? ST_FIN : ST_RDA;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/bfl_datapath.sv
module bfl_datapath
  import bfl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  opCode_t           opSel,
  input  logic              modeImm,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic [BYTE_W-1:0] immByte,
  input  logic [BYTE_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              cmdImm,
  output logic              lastByte,
  output logic              condCode
);

  opCode_t           opR;
  logic [ADDR_W-1:0] baseA, baseB;
  logic [LEN_W-1:0]  lenR, idx;
  logic [BYTE_W-1:0] immR, aByte;
  logic              nzAcc, ccR;

  logic [BYTE_W-1:0] lhs, rhs, res;
  logic [ADDR_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      opR    <= OP_AND;
      cmdImm <= 1'b0;
      baseA  <= '0;
      baseB  <= '0;
      lenR   <= '0;
      immR   <= '0;
      idx    <= '0;
      aByte  <= '0;
      nzAcc  <= 1'b0;
      ccR    <= 1'b0;
    end else begin
      if (stb.load) begin
        opR    <= opSel;
        cmdImm <= modeImm;
        baseA  <= addrA;
        baseB  <= addrB;
        lenR   <= modeImm ? '0 : lenCode;
        immR   <= immByte;
        idx    <= '0;
        nzAcc  <= 1'b0;
      end
      if (stb.rdB) aByte <= memRdata;
      if (stb.wr) begin
        nzAcc <= nzAcc | (|res);
        idx   <= idx + 1'b1;
        if (lastByte) ccR <= nzAcc | (|res);
      end
    end
  end

  // in immediate mode the first operand arrives in the write cycle itself
  assign lhs = cmdImm ? memRdata : aByte;
  assign rhs = cmdImm ? immR : memRdata;
  assign res = applyOp(opR, lhs, rhs);

  assign offset   = ADDR_W'(idx);
  assign memAddr  = stb.rdB ? (baseB + offset) : (baseA + offset);
  assign memEn    = stb.rdA | stb.rdB | stb.wr;
  assign memWe    = stb.wr;
  assign memWdata = res;
  assign lastByte = (idx == lenR);
  assign condCode = ccR;

endmodule

// File: rtl/bytefield_logic_engine.sv
module bytefield_logic_engine
  import bfl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [1:0]        opSel,
  input  logic              modeImm,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic [7:0]        immByte,
  output logic              busy,
  output logic              done,
  output logic              condCode,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata
);

  strobe_t stb;
  logic    cmdImm, lastByte;

  bfl_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .cmdImm   (cmdImm),
    .lastByte (lastByte),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  bfl_datapath #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .opSel    (opSel),
    .modeImm  (modeImm),
    .addrA    (addrA),
    .addrB    (addrB),
    .lenCode  (lenCode),
    .immByte  (immByte),
    .memRdata (memRdata),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .cmdImm   (cmdImm),
    .lastByte (lastByte),
    .condCode (condCode)
  );

endmodule

// File: rtl/bfl_checker.sv
module bfl_checker (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic condCode,
  input logic memEn,
  input logic memWe
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R7
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(memWe));  // R7
  AST_CC_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(condCode) |-> done);  // R5
  AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (rst)
    memWe |-> memEn);  // R10
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !memEn);  // R10
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);  // R8
  AST_READ_BETWEEN_WRITES: assert property (@(posedge clk) disable iff (rst)
    memWe |=> !memWe);  // R3

endmodule

bind bytefield_logic_engine bfl_checker i_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .condCode (condCode),
  .memEn    (memEn),
  .memWe    (memWe)
);

// File: tb/test_bytefield_logic_engine.sv
module test_bytefield_logic_engine;

  localparam int ADDR_W = 16;
  localparam int LEN_W  = 8;
  localparam int MEM_N  = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              startReq = 1'b0;
  logic [1:0]        opSel = '0;
  logic              modeImm = 1'b0;
  logic [ADDR_W-1:0] addrA = '0, addrB = '0;
  logic [LEN_W-1:0]  lenCode = '0;
  logic [7:0]        immByte = '0;
  logic              busy, done, condCode, memEn, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWdata, memRdata;

  logic [7:0] mem    [MEM_N];
  logic [7:0] shadow [MEM_N];

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  bytefield_logic_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_bytefield_logic_engine (
    .clk(clk), .rst(rst), .startReq(startReq), .opSel(opSel), .modeImm(modeImm),
    .addrA(addrA), .addrB(addrB), .lenCode(lenCode), .immByte(immByte),
    .busy(busy), .done(done), .condCode(condCode), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // one-cycle-latency byte memory
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr[9:0]] <= memWdata;
      else       memRdata <= mem[memAddr[9:0]];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] refOp(input logic [1:0] op, input logic [7:0] x, input logic [7:0] y);
    if (op == 2'd0) return x & y;
    if (op == 2'd1) return x | y;
    return x ^ y;
  endfunction

  task automatic setByte(input int a, input logic [7:0] v);
    mem[a] = v;
    shadow[a] = v;
  endtask

  task automatic compareMem(input string tag);
    int bad = -1;
    for (int i = 0; i < MEM_N; i++)
      if (bad < 0 && mem[i] !== shadow[i]) bad = i;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, $sformatf("%s mem[0x%0h]", tag, bad), mem[bad], shadow[bad]);
  endtask

  task automatic runOp(input string tag, input logic [1:0] op, input logic imm,
                       input int a, input int b, input int lenc,
                       input logic [7:0] iv, input int intrude);
    int n = imm ? 1 : lenc + 1;
    int cnt = 0;
    bit nz = 1'b0;
    logic ccSeen;
    for (int i = 0; i < n; i++) begin
      logic [7:0] r = refOp(op, shadow[(a+i)%MEM_N], imm ? iv : shadow[(b+i)%MEM_N]);
      shadow[(a+i)%MEM_N] = r;
      if (r != 0) nz = 1'b1;
    end
    @(negedge clk);
    opSel = op; modeImm = imm; addrA = ADDR_W'(a); addrB = ADDR_W'(b);
    lenCode = LEN_W'(lenc); immByte = iv; startReq = 1'b1;
    forever begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) startReq = 1'b0;
      if (intrude > 1 && cnt == intrude) begin
        // R8: bogus command that would zero byte 0x3F0
        startReq = 1'b1; modeImm = 1'b1; opSel = 2'd0; addrA = 16'h03F0; immByte = 8'h00;
      end
      if (intrude > 1 && cnt == intrude + 1) startReq = 1'b0;
      if (done || cnt > 3000) break;
    end
    check(cnt == (imm ? 3 : 3*n + 1), {tag, " R10 cycles"}, cnt, imm ? 3 : 3*n + 1);
    check(condCode == nz, {tag, " R5 condCode"}, condCode, nz);
    ccSeen = condCode;
    @(negedge clk);
    check(!done && !busy, {tag, " R7 done single pulse"}, done, 0);
    check(condCode == ccSeen, {tag, " R7 condCode held"}, condCode, ccSeen);
    compareMem({tag, " memory"});
  endtask

  task automatic testReset();
    check(!busy && !done && !condCode && !memEn, "R9 reset state",
          {busy, done, condCode, memEn}, 0);
  endtask

  task automatic testImmediate();
    setByte(16'h010, 8'hC5);
    runOp("R4 R1 imm AND", 2'd0, 1'b1, 16'h010, 0, 7, 8'hFA, 0);
    check(mem[16'h010] == 8'hC0, "R4 AND C5/FA", mem[16'h010], 8'hC0);
    setByte(16'h011, 8'h05);
    runOp("R4 R1 imm OR", 2'd1, 1'b1, 16'h011, 0, 200, 8'hF0, 0);
    check(mem[16'h011] == 8'hF5, "R4 OR 05/F0", mem[16'h011], 8'hF5);
    setByte(16'h012, 8'h3C);
    runOp("R4 R1 imm XOR to zero", 2'd2, 1'b1, 16'h012, 0, 3, 8'h3C, 0);
  endtask

  task automatic testField();
    runOp("R2 R1 field AND", 2'd0, 1'b0, 16'h020, 16'h040, 3, 8'h00, 0);
    runOp("R2 R1 field OR", 2'd1, 1'b0, 16'h060, 16'h080, 5, 8'h00, 0);
    runOp("R2 R1 field XOR op3", 2'd3, 1'b0, 16'h0A0, 16'h0C0, 2, 8'h00, 0);
    runOp("R2 single byte", 2'd2, 1'b0, 16'h0E0, 16'h0E8, 0, 8'h00, 0);
  endtask

  task automatic testSameAddrXor();
    runOp("R6 self XOR", 2'd2, 1'b0, 16'h120, 16'h120, 7, 8'h00, 0);
    for (int i = 0; i < 8; i++)
      check(mem[16'h120 + i] == 8'h00, "R6 field cleared", mem[16'h120 + i], 0);
  endtask

  task automatic testZeroResult();
    for (int i = 0; i < 4; i++) setByte(16'h140 + i, 8'h00);
    runOp("R5 AND with zeros", 2'd0, 1'b0, 16'h130, 16'h140, 3, 8'h00, 0);
    check(condCode == 1'b0, "R5 zero result", condCode, 0);
  endtask

  task automatic testOverlap();
    runOp("R3 overlap XOR", 2'd2, 1'b0, 16'h161, 16'h160, 4, 8'h00, 0);
  endtask

  task automatic testMaxLen();
    runOp("R2 256 bytes OR", 2'd1, 1'b0, 16'h100, 16'h200, 255, 8'h00, 0);
  endtask

  task automatic testBusyIgnore();
    runOp("R8 start while busy", 2'd1, 1'b0, 16'h300, 16'h320, 3, 8'h00, 4);
    check(mem[16'h3F0] == shadow[16'h3F0], "R8 bogus target untouched",
          mem[16'h3F0], shadow[16'h3F0]);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    opSel = 2'd1; modeImm = 1'b0; addrA = 16'h340; addrB = 16'h360;
    lenCode = 8'd9; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && !condCode && !memEn, "R9 reset mid-operation",
          {busy, done, condCode, memEn}, 0);
    @(negedge clk);
    check(!memEn && !busy, "R9 stays idle", memEn, 0);
    for (int i = 0; i < MEM_N; i++) shadow[i] = mem[i];
    runOp("R9 op after reset", 2'd2, 1'b0, 16'h380, 16'h3A0, 2, 8'h00, 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'((i * 37 + 11) & 8'hFF);
      shadow[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testImmediate();
    testField();
    testSameAddrXor();
    testZeroResult();
    testOverlap();
    testMaxLen();
    testBusyIgnore();
    testMidReset();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

endmodule